// File: doc/BRIEF.md
# Control Register Mask and Shadow Unit

This unit mediates a guest's access to one virtualized control register. A per-bit ownership mask splits the register into host-owned and guest-owned bits. A read shadow supplies the values the guest is shown for host-owned bits. On a read, the unit merges shadow bits in host-owned positions with real-register bits in guest-owned positions. On a write, it compares each host-owned bit the operation touches against the shadow. Any mismatch raises an exit, and the real register is left as it was. Otherwise the guest-owned bits are written.

The unit supports five operations:
- a full-width read;
- a read of the low 16 bits only;
- a full-width write;
- a clear of the task-switched flag (bit 3);
- a load of the low status nibble (bits 3:0).

The register width is a parameter and may be 32 or 64. The mask and shadow are level inputs that the surrounding logic holds steady. Each accepted request gets its response one cycle later.

Top module: `cr_shadow_unit`

## Requirements
- R1: While rst_ni is low and after its release, `cr_o` equals the parameter RST_VAL, and `rsp_valid_o`, `rsp_exit_o` and `rsp_data_o` are zero.
- R2: Op code 0 (full read) returns, on the cycle after the request, `(shadow_i & mask_i) | (cr & ~mask_i)`.
- R3: Op code 1 (low read) returns the low 16 bits of the R2 merge, with the upper bits zero.
- R4: Op code 2 (full write) raises `rsp_exit_o` one cycle later exactly when some bit has mask 1 and a data bit that differs from the shadow bit.
- R5: A write that does not exit copies the new value into guest-owned bits (mask 0). Host-owned bits of the real register keep their old value, even when the written value matches the shadow but differs from the real register.
- R6: A write that exits leaves every bit of the real register unchanged.
- R7: Op code 3 (clear task-switched) acts as a write of the current register with bit 3 cleared. Only bit 3 is compared, so the operation exits exactly when mask bit 3 and shadow bit 3 are both 1.
- R8: Op code 4 (load low status) writes only bits 3:0, and only those bits are compared. Bits 3:1 come from data, and bit 0 becomes data bit 0 OR the current bit 0, so the load cannot clear bit 0. Data bits above 3 are ignored.
- R9: Read ops never raise `rsp_exit_o`, never change the register, and return zero data on write ops.
- R10: When `req_valid_i` is low, or for op codes 5 to 7, there is no response and the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code (see R2 to R10) |
| req_data_i | input | XLEN | Write data |
| mask_i | input | XLEN | Ownership mask, 1 = host-owned |
| shadow_i | input | XLEN | Read shadow |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_data_o | output | XLEN | Read result |
| rsp_exit_o | output | 1 | Write trapped to host |
| cr_o | output | XLEN | Real register value |

## Verification
The bench targets writes whose host-owned bits match the shadow but differ from the real register. A design that compares against the real register would exit wrongly there, and a design that copies the written value would overwrite host bits.

The partial operations are tested with host-owned upper bits that disagree with the shadow. A design that compares the full width on these operations would exit on every clear or status load.

The status load is driven with bit 0 set in the register and clear in the data. A design without the sticky OR would clear that bit.

Exiting writes are followed by a read-back of the register. A design that commits guest bits before deciding to exit would show a modified value.

// File: rtl/cr_shadow_pkg.sv
package cr_shadow_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_RD_FULL = 3'd0;
  localparam logic [OP_W-1:0] OP_RD_LOW  = 3'd1;
  localparam logic [OP_W-1:0] OP_WR_FULL = 3'd2;
  localparam logic [OP_W-1:0] OP_CLR_TS  = 3'd3;
  localparam logic [OP_W-1:0] OP_LD_LOW  = 3'd4;
  localparam int unsigned TS_BIT   = 3;
  localparam int unsigned LOW_RD_W = 16;
  localparam int unsigned LD_W     = 4;
endpackage

// File: rtl/cr_write_cand.sv
module cr_write_cand
  import cr_shadow_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] cr_i,
  input  logic [XLEN-1:0] data_i,
  output logic            is_wr_o,
  output logic [XLEN-1:0] cand_o,
  output logic [XLEN-1:0] touch_o
);
  always_comb begin
    cand_o  = cr_i;
    touch_o = '0;
    is_wr_o = 1'b0;
    unique case (op_i)
      OP_WR_FULL: begin
        is_wr_o = 1'b1;
        cand_o  = data_i;
        touch_o = '1;
      end
      OP_CLR_TS: begin
        is_wr_o         = 1'b1;
        cand_o[TS_BIT]  = 1'b0;
        touch_o[TS_BIT] = 1'b1;
      end
      OP_LD_LOW: begin
        is_wr_o             = 1'b1;
        cand_o[LD_W-1:1]    = data_i[LD_W-1:1];
        cand_o[0]           = data_i[0] | cr_i[0]; // status load never clears bit 0
        touch_o[LD_W-1:0]   = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cr_trap_check.sv
module cr_trap_check #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] shadow_i,
  input  logic [XLEN-1:0] cr_i,
  input  logic [XLEN-1:0] cand_i,
  input  logic [XLEN-1:0] touch_i,
  output logic            trap_o,
  output logic [XLEN-1:0] next_o
);
  logic [XLEN-1:0] host_diff;
  logic [XLEN-1:0] guest_wr;

  assign host_diff = mask_i & touch_i & (cand_i ^ shadow_i);
  assign trap_o    = |host_diff;
  assign guest_wr  = ~mask_i & touch_i;
  assign next_o    = (cr_i & ~guest_wr) | (cand_i & guest_wr);
endmodule

// File: rtl/cr_read_merge.sv
module cr_read_merge
  import cr_shadow_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] shadow_i,
  input  logic [XLEN-1:0] cr_i,
  output logic            is_rd_o,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] merged;

  assign merged = (shadow_i & mask_i) | (cr_i & ~mask_i);

  always_comb begin
    is_rd_o = 1'b0;
    data_o  = '0;
    if (op_i == OP_RD_FULL) begin
      is_rd_o = 1'b1;
      data_o  = merged;
    end else if (op_i == OP_RD_LOW) begin
      is_rd_o = 1'b1;
      data_o[LOW_RD_W-1:0] = merged[LOW_RD_W-1:0];
    end
  end
endmodule

// File: rtl/cr_shadow_unit.sv
module cr_shadow_unit
  import cr_shadow_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter logic [63:0] RST_VAL = 64'h0000_0000_0000_0011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [2:0]      req_op_i,
  input  logic [XLEN-1:0] req_data_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] shadow_i,
  output logic            rsp_valid_o,
  output logic [XLEN-1:0] rsp_data_o,
  output logic            rsp_exit_o,
  output logic [XLEN-1:0] cr_o
);
  localparam logic [XLEN-1:0] RST_CR = RST_VAL[XLEN-1:0];

  logic [XLEN-1:0] cr_q, cand, touch, next_cr, rd_data, data_q;
  logic            is_wr, is_rd, trap, valid_q, exit_q;

  cr_write_cand #(.XLEN(XLEN)) u_cand (
    .op_i(req_op_i), .cr_i(cr_q), .data_i(req_data_i),
    .is_wr_o(is_wr), .cand_o(cand), .touch_o(touch)
  );

  cr_trap_check #(.XLEN(XLEN)) u_trap (
    .mask_i(mask_i), .shadow_i(shadow_i), .cr_i(cr_q), .cand_i(cand),
    .touch_i(touch), .trap_o(trap), .next_o(next_cr)
  );

  cr_read_merge #(.XLEN(XLEN)) u_rd (
    .op_i(req_op_i), .mask_i(mask_i), .shadow_i(shadow_i), .cr_i(cr_q),
    .is_rd_o(is_rd), .data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q    <= RST_CR;
      valid_q <= 1'b0;
      exit_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= req_valid_i & (is_wr | is_rd);
      exit_q  <= req_valid_i & is_wr & trap;
      data_q  <= (req_valid_i & is_rd) ? rd_data : '0;
      if (req_valid_i && is_wr && !trap) cr_q <= next_cr;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_exit_o  = exit_q;
  assign rsp_data_o  = data_q;
  assign cr_o        = cr_q;

  p_exit_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_wr && trap) |=> ($stable(cr_q) && rsp_exit_o));

  p_host_bits_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_wr) |=> (((cr_q ^ $past(cr_q)) & $past(mask_i)) == '0));

  p_read_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_rd) |=> ($stable(cr_q) && !rsp_exit_o && rsp_valid_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i) |=> (!rsp_valid_o && !rsp_exit_o && $stable(cr_q)));

  p_pe_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_LD_LOW && cr_q[0]) |=> cr_q[0]);

  p_ts_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_CLR_TS && !mask_i[TS_BIT]) |=> !cr_q[TS_BIT]);

  p_low_read_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_RD_LOW) |=> (rsp_data_o[XLEN-1:LOW_RD_W] == '0));
endmodule

// File: tb/cr_shadow_unit_tb.sv
`timescale 1ns/1ps
module cr_shadow_unit_tb;
  localparam int XLEN = 64;
  localparam logic [63:0] RSTV = 64'h0000_0000_0000_0011;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [2:0]      req_op_i = '0;
  logic [XLEN-1:0] req_data_i = '0, mask_i = '0, shadow_i = '0;
  logic            rsp_valid_o, rsp_exit_o;
  logic [XLEN-1:0] rsp_data_o, cr_o;

  int checks = 0, fails = 0;
  logic [XLEN-1:0] m_cr;

  always #2.5 clk_i = ~clk_i;

  cr_shadow_unit #(.XLEN(XLEN), .RST_VAL(RSTV)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_data_i, .mask_i, .shadow_i,
    .rsp_valid_o, .rsp_data_o, .rsp_exit_o, .cr_o
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] merge_f(input logic [XLEN-1:0] cr, mk, sh);
    return (sh & mk) | (cr & ~mk);
  endfunction

  task automatic run(input logic v, input logic [2:0] op, input logic [XLEN-1:0] d, input string tag);
    logic [XLEN-1:0] e_data, tgt, upd;
    logic e_valid, e_exit, wr;
    e_data = '0; e_exit = 1'b0; tgt = '0; upd = m_cr; wr = 1'b0;
    e_valid = v && (op <= 3'd4);
    if (v && op == 3'd0) e_data = merge_f(m_cr, mask_i, shadow_i);
    if (v && op == 3'd1) e_data = {48'h0, merge_f(m_cr, mask_i, shadow_i)[15:0]};
    if (v && op == 3'd2) begin wr = 1'b1; tgt = '1; upd = d; end
    if (v && op == 3'd3) begin wr = 1'b1; tgt[3] = 1'b1; upd[3] = 1'b0; end
    if (v && op == 3'd4) begin
      wr = 1'b1; tgt[3:0] = 4'hF; upd[3:1] = d[3:1]; upd[0] = d[0] | m_cr[0];
    end
    if (wr) begin
      e_exit = |(mask_i & tgt & (upd ^ shadow_i));
      if (!e_exit) m_cr = (m_cr & mask_i) | (upd & ~mask_i);
    end
    @(negedge clk_i);
    req_valid_i = v; req_op_i = op; req_data_i = d;
    @(posedge clk_i); #1;
    chk({tag, " valid"}, {63'b0, rsp_valid_o}, {63'b0, e_valid});
    chk({tag, " exit"},  {63'b0, rsp_exit_o},  {63'b0, e_exit});
    chk({tag, " data"},  rsp_data_o, e_data);
    chk({tag, " cr"},    cr_o, m_cr);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  function automatic logic [XLEN-1:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cr = RSTV;
    #12;
    chk("R1 reset cr", cr_o, RSTV);
    chk("R1 reset valid", {63'b0, rsp_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release cr", cr_o, RSTV);
    chk("R1 after release data", rsp_data_o, 64'd0);

    mask_i = 64'hFFFF_0000_0000_F0F0; shadow_i = 64'h1234_0000_0000_A050;
    run(1, 3'd0, '0, "R2 full read");
    run(1, 3'd1, '0, "R3 low read");
    // host bit differs from shadow: exit, register frozen
    run(1, 3'd2, 64'h1235_0000_0000_A0FF, "R4 R6 trap write");
    // host bits equal shadow, differ from real: no exit, host bits kept
    run(1, 3'd2, 64'h1234_0000_0000_A05F, "R5 guest write");
    run(1, 3'd0, '0, "R5 readback");
    // clear task-switched cases
    mask_i = 64'hFFFF_FFFF_FFFF_FFF8; shadow_i = 64'h8;
    run(1, 3'd3, '0, "R7 clr trap");
    shadow_i = 64'h0;
    run(1, 3'd3, '0, "R7 clr host owned");
    mask_i = 64'hFFFF_0000_0000_0000; shadow_i = 64'h0;
    run(1, 3'd2, 64'h0000_0000_0000_0009, "R5 set ts");
    run(1, 3'd3, '0, "R7 clr guest owned");
    // status load: upper host bits disagree with shadow, no full compare
    mask_i = 64'hFFFF_0000_0000_0000; shadow_i = 64'hFFFF_0000_0000_0000;
    run(1, 3'd4, 64'hFFFF_FFFF_FFFF_FFF0, "R8 ld sticky bit0");
    run(1, 3'd4, 64'h0000_0000_0000_000E, "R8 ld nibble");
    mask_i = 64'h2; shadow_i = 64'h0;
    run(1, 3'd4, 64'h0000_0000_0000_0002, "R8 ld trap");
    run(0, 3'd2, 64'hDEAD_BEEF_DEAD_BEEF, "R10 idle");
    run(1, 3'd7, 64'hDEAD_BEEF_DEAD_BEEF, "R10 bad op");
    run(1, 3'd5, 64'h0, "R10 bad op5");
    run(1, 3'd0, '0, "R9 read after");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      if (i % 16 == 0) begin
        mask_i   = r64() & r64();
        shadow_i = r64();
      end
      op = 3'($urandom_range(0, 5));
      case (op)
        3'd0: run(1, op, r64(), "R2 rnd");
        3'd1: run(1, op, r64(), "R3 rnd");
        3'd2: run(1, op, ($urandom_range(0, 1) != 0) ?
                   ((shadow_i & mask_i) | (r64() & ~mask_i)) : r64(), "R4 R5 R6 rnd");
        3'd3: run(1, op, r64(), "R7 rnd");
        3'd4: run(1, op, r64(), "R8 rnd");
        default: run($urandom_range(0, 1) != 0, 3'd2 + 3'(3 * $urandom_range(0, 1)), r64(), "R10 rnd");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule